// File: doc/BRIEF.md
# AES-128 Round Key Sequencer

This block turns a 128-bit cipher key into the eleven 128-bit round keys that an AES-128 datapath consumes, one key per clock. A single start pulse captures the cipher key together with a direction bit; after that the block walks the key schedule on its own and presents each key with its round index and a valid strobe. A done pulse follows the last key.

In forward order the keys appear as an encryption round sequence needs them: index 0, which is the cipher key itself, up to index 10. In reverse order a decryption datapath gets the final key first. The block first spends ten silent cycles running the schedule forward to reach round 10. It then steps back through the inverted recurrence down to the original key, so no table of eleven keys is ever stored. The byte-substitution function is computed in logic inside the block rather than held as a table.

Top module: `rkey_sequencer`

## Requirements
- R1: During and after a synchronous active-low reset, `rk_valid_o` and `done_o` are 0 until a start is accepted.
- R2: When a start is accepted with `reverse_i`=0, the next cycle shows `rk_valid_o`=1, `rk_idx_o`=0 and `rk_o` equal to the captured key. Byte n of a key sits in bits 127-8n down to 120-8n, so byte 0 is the most significant.
- R3: In forward order, keys with indices 0,1,...,10 appear on eleven consecutive cycles. Each key r+1 is built from key r: word 0 is word 0 XOR SubBytes(rotate-left-by-one-byte(word 3)) XOR {rc,24'h0}, and each later word is the old word XOR the new word before it. Word 0 is bits 127:96.
- R4: The round constant for key r (r=1..10) is 01,02,04,08,10,20,40,80,1B,36 in turn.
- R5: When a start is accepted with `reverse_i`=1, `rk_valid_o` stays 0 for the next ten cycles. On the eleventh cycle after the start cycle, the round-10 key appears with `rk_idx_o`=10.
- R6: In reverse order, keys with indices 10,9,...,0 appear on eleven consecutive cycles and match the forward schedule. The final key equals the captured cipher key.
- R7: `done_o` is 1 for exactly the one cycle after the last valid key, and `rk_valid_o` is 0 in that cycle.
- R8: A start pulse that arrives while a sequence is in progress is ignored: the running keys, indices and order are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a sequence; accepted only when idle |
| key_i | input | 128 | Cipher key, sampled with an accepted start |
| reverse_i | input | 1 | 0: keys in increasing round order; 1: decreasing order; sampled with start |
| rk_o | output | 128 | Current round key |
| rk_idx_o | output | 4 | Round index of `rk_o` |
| rk_valid_o | output | 1 | `rk_o` and `rk_idx_o` hold a key of the sequence |
| done_o | output | 1 | One-cycle pulse after the last key |

## Verification
Two functions can meet in the same cycle: a key being emitted while a new start request arrives. A start can also coincide with the silent forward warm-up of a reverse run. The bench raises start with a different key and the opposite direction in the middle of a forward sequence. It also does this during the warm-up of a reverse sequence. It then requires every remaining key, index and the done pulse to match the original run. A reset applied mid-sequence must also clear the strobes at once.

// File: rtl/rkey_pkg.sv
// Package rkey_pkg
// Shared widths and the finite-field helpers used by the round key sequencer.
// Assumes AES-128: four 32-bit words per key, ten schedule steps.
package rkey_pkg;
    localparam int KEY_W   = 128;
    localparam int WORD_W  = 32;
    localparam int NWORDS  = KEY_W / WORD_W;
    localparam int NSTEPS  = 10;
    localparam int IDX_W   = $clog2(NSTEPS + 1);
    localparam int BYTE_W  = 8;
    localparam int WBYTES  = WORD_W / BYTE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef enum logic [1:0] {ST_IDLE, ST_WARM, ST_EMIT, ST_FIN} seq_state_t;

    // Multiply by x modulo x^8+x^4+x^3+x+1.
    function automatic byte_t gf_xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General product in GF(2^8).
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t p = 8'h00;
        byte_t t = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) p = p ^ t;
            t = gf_xtime(t);
        end
        return p;
    endfunction

    // Forward S-box value: inverse (x^254) followed by the affine map.
    function automatic byte_t sbox_calc(input byte_t a);
        byte_t inv = 8'h01;
        byte_t sq  = a;
        byte_t r1, r2, r3, r4;
        for (int i = 1; i < BYTE_W; i++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        r1 = {inv[6:0], inv[7]};
        r2 = {inv[5:0], inv[7:6]};
        r3 = {inv[4:0], inv[7:5]};
        r4 = {inv[3:0], inv[7:4]};
        return inv ^ r1 ^ r2 ^ r3 ^ r4 ^ 8'h63;
    endfunction

    // Round constant used to build key r (r = 1..NSTEPS).
    function automatic byte_t rcon_calc(input logic [IDX_W-1:0] r);
        byte_t c = 8'h01;
        for (int i = 1; i < NSTEPS; i++) begin
            if (i < int'(r)) c = gf_xtime(c);
        end
        return c;
    endfunction
endpackage

// File: rtl/rkey_sbox.sv
// Module rkey_sbox
// One byte substitution computed from field arithmetic; purely combinational.
// Assumes the caller tolerates the logic depth of an unrolled inverse.
module rkey_sbox
    import rkey_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    output logic [BYTE_W-1:0] y_o
);
    // Substitute one byte.
    always_comb y_o = sbox_calc(a_i);
endmodule

// File: rtl/rkey_step.sv
// Module rkey_step
// One schedule step, either direction: forward builds key r+1 from key r,
// backward rebuilds key r-1 from key r. A single word of substitution boxes
// is shared; the substituted word is the old word 3 in both cases.
// Assumes rcon_i is the constant of the higher-numbered key of the pair.
module rkey_step
    import rkey_pkg::*;
(
    input  logic [KEY_W-1:0]  cur_i,
    input  logic              back_i,
    input  logic [BYTE_W-1:0] rcon_i,
    output logic [KEY_W-1:0]  nxt_o
);
    word_t cw [NWORDS];
    word_t fw [NWORDS];
    word_t bw [NWORDS];
    word_t tail, rot, sub, mix;

    genvar g;
    generate
        for (g = 0; g < NWORDS; g++) begin : g_unpack
            assign cw[g] = cur_i[KEY_W-1-g*WORD_W -: WORD_W];
        end
    endgenerate

    // Pick the word that feeds the substitution: old word 3 for either direction.
    always_comb tail = back_i ? (cw[NWORDS-1] ^ cw[NWORDS-2]) : cw[NWORDS-1];
    // Rotate the word left by one byte.
    always_comb rot  = {tail[WORD_W-BYTE_W-1:0], tail[WORD_W-1 -: BYTE_W]};

    generate
        for (g = 0; g < WBYTES; g++) begin : g_sbox
            rkey_sbox u_sb (.a_i(rot[g*BYTE_W +: BYTE_W]), .y_o(sub[g*BYTE_W +: BYTE_W]));
        end
    endgenerate

    // Fold in the round constant on the top byte.
    always_comb mix = sub ^ {rcon_i, {(WORD_W-BYTE_W){1'b0}}};

    assign fw[0] = cw[0] ^ mix;
    assign bw[0] = cw[0] ^ mix;
    generate
        for (g = 1; g < NWORDS; g++) begin : g_chain
            assign fw[g] = cw[g] ^ fw[g-1];
            assign bw[g] = cw[g] ^ cw[g-1];
        end
        for (g = 0; g < NWORDS; g++) begin : g_pack
            assign nxt_o[KEY_W-1-g*WORD_W -: WORD_W] = back_i ? bw[g] : fw[g];
        end
    endgenerate
endmodule

// File: rtl/rkey_sequencer.sv
// Module rkey_sequencer
// Emits the eleven AES-128 round keys, one per clock, in increasing or
// decreasing round order. Reverse order first runs the forward schedule for
// NSTEPS silent cycles, then walks back. Start is honoured only when idle.
// Assumes a synchronous active-low reset.
module rkey_sequencer
    import rkey_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [127:0]     key_i,
    input  logic             reverse_i,
    output logic [127:0]     rk_o,
    output logic [3:0]       rk_idx_o,
    output logic             rk_valid_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NSTEPS);

    seq_state_t        state;
    logic [KEY_W-1:0]  cur_q, nxt;
    logic [IDX_W-1:0]  rnd_q, rc_idx;
    logic              dir_q, back, at_end;
    logic [BYTE_W-1:0] rc;

    // Backward stepping happens only while emitting a reverse sequence.
    always_comb back   = (state == ST_EMIT) && dir_q;
    // Constant belongs to the higher-numbered key of the step pair.
    always_comb rc_idx = back ? rnd_q : rnd_q + 1'b1;
    always_comb rc     = rcon_calc(rc_idx);
    // Last key of the current order.
    always_comb at_end = dir_q ? (rnd_q == '0) : (rnd_q == LAST);

    rkey_step u_step (.cur_i(cur_q), .back_i(back), .rcon_i(rc), .nxt_o(nxt));

    // Sequence control and key register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur_q <= '0;
            rnd_q <= '0;
            dir_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    cur_q <= key_i;
                    rnd_q <= '0;
                    dir_q <= reverse_i;
                    state <= reverse_i ? ST_WARM : ST_EMIT;
                end
                ST_WARM: begin
                    cur_q <= nxt;
                    rnd_q <= rnd_q + 1'b1;
                    if (rnd_q == LAST - 1'b1) state <= ST_EMIT;
                end
                ST_EMIT: begin
                    if (at_end) begin
                        state <= ST_FIN;
                    end else begin
                        cur_q <= nxt;
                        rnd_q <= dir_q ? rnd_q - 1'b1 : rnd_q + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the ports from the registered state.
    always_comb begin
        rk_o       = cur_q;
        rk_idx_o   = rnd_q;
        rk_valid_o = (state == ST_EMIT);
        done_o     = (state == ST_FIN);
    end

    // R2: a forward start yields the captured key at index 0 next cycle.
    a_r2_first_key: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state == ST_IDLE && !reverse_i) |=>
            (rk_valid_o && rk_idx_o == 4'd0 && rk_o == $past(key_i)));
    // R3: forward indices rise by one on consecutive cycles.
    a_r3_idx_up: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_valid_o && !dir_q && rk_idx_o != 4'd10) |=>
            (rk_valid_o && rk_idx_o == $past(rk_idx_o) + 4'd1));
    // R6: reverse indices fall by one on consecutive cycles.
    a_r6_idx_down: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_valid_o && dir_q && rk_idx_o != 4'd0) |=>
            (rk_valid_o && rk_idx_o == $past(rk_idx_o) - 4'd1));
    // R5: a reverse start gives no valid key in the following cycle.
    a_r5_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state == ST_IDLE && reverse_i) |=> !rk_valid_o);
    // R7: done follows the last key and never overlaps a valid key.
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_valid_o && at_end) |=> (done_o && !rk_valid_o));
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8: a start while busy leaves the order untouched.
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state != ST_IDLE) |=> (dir_q == $past(dir_q)));
endmodule

// File: tb/sim_rkey_sequencer.sv
module sim_rkey_sequencer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] key_i = '0;
    logic         reverse_i = 1'b0;
    logic [127:0] rk_o;
    logic [3:0]   rk_idx_o;
    logic         rk_valid_o;
    logic         done_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rkey_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
        .reverse_i(reverse_i), .rk_o(rk_o), .rk_idx_o(rk_idx_o),
        .rk_valid_o(rk_valid_o), .done_o(done_o)
    );

    // Expected schedule for key 2b7e1516..., index 0..10 (R3, R4 constants inside)
    localparam logic [127:0] VEC [11] = '{
        128'h2b7e151628aed2a6abf7158809cf4f3c,
        128'ha0fafe1788542cb123a339392a6c7605,
        128'hf2c295f27a96b9435935807a7359f67f,
        128'h3d80477d4716fe3e1e237e446d7a883b,
        128'hef44a541a8525b7fb671253bdb0bad00,
        128'hd4d1c6f87c839d87caf2b8bc11f915bc,
        128'h6d88a37a110b3efddbf98641ca0093fd,
        128'h4e54f70e5f5fc9f384a64fb24ea6dc4f,
        128'head27321b58dbad2312bf5607f8d292f,
        128'hac7766f319fadc2128d12941575c006e,
        128'hd014f9a8c9ee2589e13f0cc8b6630ca6
    };
    localparam logic [127:0] ZERO_K1  = 128'h62636363626363636263636362636363;
    localparam logic [127:0] ZERO_K10 = 128'hb4ef5bcb3e92e21123e951cf6f8f188e;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic begin_run(input logic [127:0] k, input logic rev);
        key_i = k; reverse_i = rev; start_i = 1'b1;
        tick();
        start_i = 1'b0; key_i = '0; reverse_i = ~rev;
    endtask

    task automatic finish_check();
        check("R7 done high", 128'(done_o), 128'd1);
        check("R7 valid low with done", 128'(rk_valid_o), 128'd0);
        tick();
        check("R7 done one cycle", 128'(done_o), 128'd0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(); tick();
        check("R1 valid in reset", 128'(rk_valid_o), 128'd0);
        check("R1 done in reset", 128'(done_o), 128'd0);
        rst_n = 1'b1;
        tick();
        check("R1 valid after reset", 128'(rk_valid_o), 128'd0);
        check("R1 done after reset", 128'(done_o), 128'd0);

        // Forward walk over the table, with a busy start at index 3 (R2, R3, R4, R8)
        begin_run(VEC[0], 1'b0);
        for (int r = 0; r <= 10; r++) begin
            check($sformatf("R3 valid idx %0d", r), 128'(rk_valid_o), 128'd1);
            check($sformatf("R3 idx %0d", r), 128'(rk_idx_o), 128'(r));
            check($sformatf("R3 R4 key idx %0d", r), rk_o, VEC[r]);
            if (r == 3) begin
                start_i = 1'b1; key_i = ZERO_K10; reverse_i = 1'b1;   // R8 ignored
            end
            tick();
            start_i = 1'b0;
        end
        finish_check();

        // Reverse walk over the table, with a busy start during warm-up (R5, R6, R8)
        begin_run(VEC[0], 1'b1);
        for (int c = 1; c <= 10; c++) begin
            check($sformatf("R5 silent cycle %0d", c), 128'(rk_valid_o), 128'd0);
            if (c == 4) begin
                start_i = 1'b1; key_i = VEC[5]; reverse_i = 1'b0;     // R8 ignored
            end
            tick();
            start_i = 1'b0;
        end
        for (int r = 10; r >= 0; r--) begin
            check($sformatf("R6 valid idx %0d", r), 128'(rk_valid_o), 128'd1);
            check($sformatf("R6 idx %0d", r), 128'(rk_idx_o), 128'(r));
            check($sformatf("R6 key idx %0d", r), rk_o, VEC[r]);
            tick();
        end
        finish_check();

        // All-zero key: forward first steps and reverse endpoints (R2, R4, R5, R6)
        begin_run('0, 1'b0);
        check("R2 zero key idx0", rk_o, 128'h0);
        tick();
        check("R4 zero key idx1", rk_o, ZERO_K1);
        for (int i = 0; i < 10; i++) tick();
        finish_check();

        begin_run('0, 1'b1);
        for (int i = 0; i < 10; i++) tick();
        check("R5 zero key first idx", 128'(rk_idx_o), 128'd10);
        check("R5 zero key first", rk_o, ZERO_K10);
        for (int i = 0; i < 9; i++) tick();
        check("R6 zero key idx1", rk_o, ZERO_K1);
        tick();
        check("R6 zero key idx0", rk_o, 128'h0);
        tick();
        finish_check();

        // Byte order: byte 0 in the top bits (R2)
        begin_run(128'h00112233445566778899aabbccddeeff, 1'b0);
        check("R2 byte order", rk_o, 128'h00112233445566778899aabbccddeeff);
        check("R2 idx", 128'(rk_idx_o), 128'd0);
        tick(); tick();

        // Reset in mid-run clears strobes (R1)
        rst_n = 1'b0;
        tick();
        check("R1 valid on mid-run reset", 128'(rk_valid_o), 128'd0);
        check("R1 done on mid-run reset", 128'(done_o), 128'd0);
        rst_n = 1'b1;
        tick();
        check("R1 stays idle", 128'(rk_valid_o), 128'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule